// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Aggregator

This block takes a set of active-high, level-sensitive peripheral interrupt lines. It gives every CPU in the cluster its own private bank of mask and pending registers. A source reaches a CPU only when that CPU's mask bit for the source is set. Software can therefore route any source to any subset of CPUs by programming each CPU's bank on its own. Each CPU receives one interrupt line, which is the OR of all its unmasked active sources, registered once.

A word-addressed register bus reaches the banks. Every CPU owns an eight-word window, which is 0x20 bytes. The upper address bits select the CPU and the low three bits select a word inside that window. There is no priority encoder, no pending FIFO, no edge or polarity setting and no bit-set or bit-clear alias. Software reads every pending word in its bank, and it changes mask bits by read-modify-write of whole words.

Top module: `irq_affinity_agg`

## Requirements
- R1: The line count parameter `NUM_LINES` must be 32, 64 or 128. This gives `NW = NUM_LINES/32` mask/pending word pairs per CPU.
- R2: After reset every mask word reads zero, and every bit of `irq_o` is low until software sets a mask bit.
- R3: A write to word offset k, with 0 ≤ k < NW, in CPU c's window replaces mask word k of CPU c with the full write data. It does not OR or clear bits into the old value.
- R4: A read of word offset NW+k in CPU c's window returns `src_i[32k+31:32k]` AND CPU c's mask word k.
- R5: Pending words are read-only. A write to offsets NW through 2NW-1 changes no mask word and no later read value.
- R6: `irq_o[c]` is high in the cycle after a rising clock edge at which any source bit and CPU c's matching mask bit were both high. It falls in the cycle after they stop overlapping.
- R7: A write reaches only the bank of the CPU whose window it addresses. Mask words of other CPUs, and the outputs of other CPUs, are unaffected.
- R8: Offsets 2NW through 7 of a window read as zero, and writes to them are ignored.
- R9: For a read issued with `req_i` high and `we_i` low at a rising edge, `rvalid_o` is high and `rdata_o` holds the result during the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_LINES | Level interrupt sources, active high |
| req_i | input | 1 | Bus access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | CPU_W+3 | Word address: {cpu, word offset} |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid when rvalid_o is high |
| rvalid_o | output | 1 | Read result valid, one cycle after the request |
| irq_o | output | NUM_CPUS | Per-CPU interrupt line |

## Verification
A corrupted mask bit has two visible effects. It either raises a CPU's `irq_o` one cycle after a masked source goes high, or it fails to raise it. It also reads back wrongly on the next bus read of that word or of its pending word. The bench therefore pairs every mask write with readbacks from the written bank and from the other banks. It toggles sources and checks each CPU's line one cycle later, so a mis-steered write or a stale output shows up within two cycles. Writes to pending and unused offsets are followed at once by readbacks of the mask words they might have touched.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned WIN_WORDS = 8;  // 0x20-byte window per CPU
  localparam int unsigned OFF_W = $clog2(WIN_WORDS);
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [OFF_W-1:0] off_t;
endpackage

// File: rtl/irq_cpu_bank.sv
module irq_cpu_bank
  import irq_agg_pkg::*;
#(
  parameter int unsigned NW = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NW*32-1:0]   src_i,
  input  logic               wr_en_i,
  input  off_t               off_i,
  input  word_t              wdata_i,
  output word_t              rdata_o,
  output logic               irq_o
);
  localparam off_t N_OFF = off_t'(NW);

  word_t [NW-1:0] en_q;
  word_t [NW-1:0] pend;
  logic           irq_q;

  for (genvar w = 0; w < NW; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[w] <= '0;
      else if (wr_en_i && off_i == off_t'(w)) en_q[w] <= wdata_i;
    end
    assign pend[w] = src_i[w*32 +: 32] & en_q[w];
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NW; w++) begin
      if (off_i == off_t'(w)) rdata_o = en_q[w];
      else if (off_i == off_t'(w) + N_OFF) rdata_o = pend[w];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else irq_q <= |pend;
  end
  assign irq_o = irq_q;

  a_r3_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && off_i < N_OFF) |=> en_q[$past(off_i)] == $past(wdata_i));
  a_r5_pend_readonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && off_i >= N_OFF) |=> $stable(en_q));
  a_r6_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(src_i & en_q)));
  a_r2_no_mask_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |=> !irq_o);
endmodule

// File: rtl/irq_bus_dec.sv
module irq_bus_dec
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 2,
  parameter int unsigned CPU_W = 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [CPU_W+OFF_W-1:0]     addr_i,
  input  word_t [NUM_CPUS-1:0]       bank_rdata_i,
  output logic [NUM_CPUS-1:0]        wr_en_o,
  output off_t                       off_o,
  output word_t                      rdata_o,
  output logic                       rvalid_o
);
  logic [CPU_W-1:0] cpu;
  word_t            rd_sel;
  word_t            rdata_q;
  logic             rvalid_q;

  assign cpu   = addr_i[CPU_W+OFF_W-1:OFF_W];
  assign off_o = addr_i[OFF_W-1:0];

  always_comb begin
    wr_en_o = '0;
    rd_sel  = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if ({1'b0, cpu} == (CPU_W+1)'(c)) begin
        wr_en_o[c] = req_i & we_i;
        rd_sel     = bank_rdata_i[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= req_i & ~we_i;
      if (req_i && !we_i) rdata_q <= rd_sel;
    end
  end
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  a_r7_single_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));
  a_r9_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  a_r9_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
endmodule

// File: rtl/irq_affinity_agg.sv
module irq_affinity_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned NUM_CPUS = 2,
  localparam int unsigned NW = NUM_LINES / 32,
  localparam int unsigned CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_LINES-1:0]   src_i,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [CPU_W+OFF_W-1:0] addr_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  output logic                   rvalid_o,
  output logic [NUM_CPUS-1:0]    irq_o
);
  initial begin
    a_r1_line_count: assert (NUM_LINES == 32 || NUM_LINES == 64 || NUM_LINES == 128)
      else $error("NUM_LINES must be 32, 64 or 128");
  end

  logic [NUM_CPUS-1:0] wr_en;
  off_t                off;
  word_t [NUM_CPUS-1:0] bank_rdata;

  irq_bus_dec #(.NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W)) u_dec (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
    .bank_rdata_i(bank_rdata), .wr_en_o(wr_en), .off_o(off),
    .rdata_o, .rvalid_o
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    irq_cpu_bank #(.NW(NW)) u_bank (
      .clk_i, .rst_ni, .src_i,
      .wr_en_i(wr_en[c]), .off_i(off), .wdata_i,
      .rdata_o(bank_rdata[c]), .irq_o(irq_o[c])
    );
  end

  a_r8_unused_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && int'(addr_i[OFF_W-1:0]) >= 2*NW) |=> rdata_o == '0);
endmodule

// File: tb/sim_irq_affinity_agg.sv
module sim_irq_affinity_agg;
  localparam int NL = 64;
  localparam int NC = 2;
  localparam int NW = NL / 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NL-1:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [NC-1:0] irq;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] en_m [NC][NW];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  irq_affinity_agg #(.NUM_LINES(NL), .NUM_CPUS(NC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq)
  );

  function automatic logic [31:0] model_rd(int c, int off);
    if (off < NW) return en_m[c][off];
    if (off < 2*NW) return src[(off-NW)*32 +: 32] & en_m[c][off-NW];
    return 32'h0;
  endfunction

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  // monitor: pop expected read data as results appear
  always @(negedge clk) begin
    cycles++;
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check("R9 unexpected rvalid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(int c, int off, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = {c[0], off[2:0]}; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    if (off < NW) en_m[c][off] = d;
  endtask

  task automatic rd(int c, int off, string t);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = {c[0], off[2:0]};
    exp_q.push_back(model_rd(c, off));
    tag_q.push_back(t);
    @(negedge clk);
    req = 1'b0;
    check("R9 rvalid after read", {31'b0, rvalid}, 32'h1);
  endtask

  task automatic set_src(logic [NL-1:0] v, string t);
    logic [NC-1:0] e;
    @(negedge clk);
    src = v;
    for (int c = 0; c < NC; c++) begin
      e[c] = 1'b0;
      for (int w = 0; w < NW; w++) e[c] |= |(v[w*32 +: 32] & en_m[c][w]);
    end
    @(negedge clk);
    check(t, {30'b0, irq}, {30'b0, e});
  endtask

  initial begin
    for (int c = 0; c < NC; c++) for (int w = 0; w < NW; w++) en_m[c][w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 irq after reset", {30'b0, irq}, 32'h0);
    for (int c = 0; c < NC; c++) for (int w = 0; w < NW; w++) rd(c, w, "R2 mask reset");
    set_src('1, "R2 masked sources give no irq");
    set_src('0, "R2 idle");
    @(negedge clk);
    check("R9 rvalid idle", {31'b0, rvalid}, 32'h0);

    wr(0, 0, 32'h0000_00F0);
    wr(1, 1, 32'h8000_0001);
    rd(0, 0, "R3 readback cpu0 w0");
    rd(1, 1, "R3 readback cpu1 w1");
    rd(1, 0, "R7 cpu1 w0 untouched");
    rd(0, 1, "R7 cpu0 w1 untouched");

    set_src(64'h8000_0000_0000_0010, "R6 both cpus raised");
    rd(0, 2, "R4 pend cpu0 w0");
    rd(0, 3, "R4 pend cpu0 w1");
    rd(1, 2, "R4 pend cpu1 w0");
    rd(1, 3, "R4 pend cpu1 w1");
    set_src('0, "R6 irq falls");
    set_src(64'h0000_0000_0000_0001, "R6 unmasked bit only");
    set_src(64'h0000_0001_0000_0000, "R7 routed to cpu1 only");
    set_src(64'h0000_0000_0000_0080, "R7 routed to cpu0 only");

    wr(0, 2, 32'hFFFF_FFFF);
    wr(0, 3, 32'hFFFF_FFFF);
    rd(0, 0, "R5 mask w0 after pend write");
    rd(0, 1, "R5 mask w1 after pend write");
    rd(0, 2, "R5 pend unchanged");

    wr(1, 5, 32'hDEAD_BEEF);
    wr(1, 7, 32'h1234_5678);
    rd(1, 5, "R8 unused offset reads zero");
    rd(1, 7, "R8 top offset reads zero");
    rd(1, 0, "R8 mask w0 unchanged");
    rd(1, 1, "R8 mask w1 unchanged");

    wr(0, 0, 32'h0000_0001);
    rd(0, 0, "R3 full word replace");
    set_src(64'h0000_0000_0000_0080, "R3 cleared bit no irq");
    set_src(64'h0000_0000_0000_0001, "R3 new bit raises irq");
    rd(1, 0, "R7 cpu1 after cpu0 write");
    set_src('0, "R6 final release");

    repeat (3) @(negedge clk);
    check("R9 queue drained", exp_q.size(), 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    checks++;
    errors++;
    $display("FAIL watchdog act=%0d exp=<5000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule